// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a 32-bit down-counter paced by a power-of-two prescaler on the base clock. Software-side logic sets it up with three write strobes that share one data word. One strobe writes a divide code. One writes a control word that holds the interrupt vector, a mask bit and a periodic-mode bit. The third writes the initial count, which starts a new countdown. The current count can be read at all times. When the count would go below zero, the block raises a one-cycle strobe that carries the programmed vector. Downstream interrupt logic takes this strobe as an edge-triggered request.

Expiry happens one tick after the count reaches zero, so one full period is initial+1 ticks. In periodic mode the counter reloads the initial value at expiry and keeps going. In one-shot mode it stays at zero and goes idle after the single expiry. The divide code is not contiguous. Bits 1:0 and bit 3 form a 3-bit value, and the shift is that value plus one, modulo eight. A code whose kept bits are all ones therefore divides by one.

Top module: `cdt_timer`

## Requirements
- R1: After reset the current count is 0 and no post is raised. The control word is masked, one-shot, vector 0. The divide code is 0, which gives shift 1. A countdown started with this control word never posts.
- R2: A divide write keeps only data bits 0, 1 and 3. The shift is ({bit3, bit1, bit0} + 1) mod 8, and one tick occurs every 2^shift base clock cycles.
- R3: An initial-count write loads the count in the next cycle and restarts the prescaler. Tick k then falls on the k*2^shift-th clock edge after the write edge.
- R4: In periodic mode (control bit 17 = 1), after t ticks the count equals initial - (t mod (initial+1)).
- R5: In one-shot mode (bit 17 = 0), the count equals initial - t and holds at 0 once t reaches initial. The count never rises except through an initial-count write. The only post comes at tick initial+1.
- R6: At an expiry with the mask bit (bit 16) clear, post_valid is high for exactly one cycle, and post_vector carries control bits 7:0. The post appears in the same cycle as the count reload.
- R7: While the mask bit is set, the count keeps running but no post is raised.
- R8: An initial count of 0 leaves the timer idle with count 0, and it never posts.
- R9: If an initial-count write lands on an expiry tick, the write wins. No post is raised, and the count takes the newly written value.
- R10: A control write on an expiry edge does not affect that expiry, which uses the previous control word. The new word governs every later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata | input | 32 | Shared write data |
| wr_init | input | 1 | Write strobe for the initial count |
| wr_div | input | 1 | Write strobe for the divide code |
| wr_ctrl | input | 1 | Write strobe for the control word |
| cur_count | output | 32 | Current count value |
| post_valid | output | 1 | One-cycle expiry strobe |
| post_vector | output | 8 | Vector carried with the strobe |

## Verification
Two pairs of events can fall in the same cycle. An expiry tick can coincide with an initial-count write, and an expiry tick can coincide with a control write. Both are provoked with divide-by-one and an initial count of 1, which puts an expiry on every second edge. The write strobe is then placed on exactly that edge. In the first case the result is judged by the absence of a post and by the count showing the written value. In the second case it is judged by the vector on that post, which must be the old one, and by the vector on the following post, which must be the new one.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
    localparam int VEC_W        = 8;
    localparam int SHIFT_W      = 3;
    localparam int PERIODIC_BIT = 17;
    localparam int MASK_BIT     = 16;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } tctrl_t;

    // kept divide bits {3,1,0} plus one, wrapping in three bits
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] code);
        logic [SHIFT_W-1:0] v;
        v = {code[3], code[1:0]};
        return v + 3'd1;
    endfunction
endpackage

// File: rtl/cdt_cfg_regs.sv
`timescale 1ns/1ps
module cdt_cfg_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wr_ctrl,
    input  logic               wr_div,
    output tctrl_t             ctrl,
    output logic [SHIFT_W-1:0] shift
);
    typedef struct packed {
        tctrl_t     ctrl;
        logic [3:0] div;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) begin
            s_d.ctrl.periodic = wdata[PERIODIC_BIT];
            s_d.ctrl.masked   = wdata[MASK_BIT];
            s_d.ctrl.vector   = wdata[VEC_W-1:0];
        end
        if (wr_div) begin
            s_d.div = {wdata[3], 1'b0, wdata[1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl.periodic <= 1'b0;
            s_q.ctrl.masked   <= 1'b1;
            s_q.ctrl.vector   <= '0;
            s_q.div           <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl  = s_q.ctrl;
    assign shift = div_shift(s_q.div);
endmodule

// File: rtl/cdt_prescaler.sv
`timescale 1ns/1ps
module cdt_prescaler
    import cdt_pkg::*;
#(
    parameter int SW = SHIFT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [SW-1:0] shift,
    output logic          tick
);
    localparam int PRE_W = (1 << SW) - 1;
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] low_mask;

    always_comb begin
        low_mask = (ONE << shift) - ONE;
        tick     = ((pre_q & low_mask) == low_mask);
        pre_d    = restart ? '0 : pre_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/cdt_countdown.sv
`timescale 1ns/1ps
module cdt_countdown
    import cdt_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_val,
    input  tctrl_t             ctrl,
    output logic [COUNT_W-1:0] count,
    output logic               post_valid,
    output logic [VEC_W-1:0]   post_vector
);
    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
        logic [COUNT_W-1:0] init;
        logic               active;
        logic               post;
        logic [VEC_W-1:0]   vec;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.post = 1'b0;
        if (load) begin
            s_d.cnt    = load_val;
            s_d.init   = load_val;
            s_d.active = |load_val;
        end else if (tick && s_q.active) begin
            if (s_q.cnt == '0) begin
                if (!ctrl.masked) begin
                    s_d.post = 1'b1;
                    s_d.vec  = ctrl.vector;
                end
                if (ctrl.periodic) s_d.cnt    = s_q.init;
                else               s_d.active = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count       = s_q.cnt;
    assign post_valid  = s_q.post;
    assign post_vector = s_q.vec;
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COUNT_W-1:0] wdata,
    input  logic               wr_init,
    input  logic               wr_div,
    input  logic               wr_ctrl,
    output logic [COUNT_W-1:0] cur_count,
    output logic               post_valid,
    output logic [VEC_W-1:0]   post_vector
);
    tctrl_t             ctrl_w;
    logic [SHIFT_W-1:0] shift_w;
    logic               tick_w;

    cdt_cfg_regs #(.DATA_W(COUNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wdata   (wdata),
        .wr_ctrl (wr_ctrl),
        .wr_div  (wr_div),
        .ctrl    (ctrl_w),
        .shift   (shift_w)
    );

    cdt_prescaler #(.SW(SHIFT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_init),
        .shift   (shift_w),
        .tick    (tick_w)
    );

    cdt_countdown #(.COUNT_W(COUNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick_w),
        .load        (wr_init),
        .load_val    (wdata),
        .ctrl        (ctrl_w),
        .count       (cur_count),
        .post_valid  (post_valid),
        .post_vector (post_vector)
    );
endmodule

// File: rtl/cdt_timer_chk.sv
`timescale 1ns/1ps
module cdt_timer_chk #(
    parameter int COUNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [COUNT_W-1:0] wdata,
    input logic               wr_init,
    input logic [COUNT_W-1:0] cur_count,
    input logic               post_valid,
    input logic               ctrl_masked,
    input logic               ctrl_periodic
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_post_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> !post_valid);

    assert_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_init && wdata == '0) |=> (cur_count == '0 && !post_valid));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_init |=> (!post_valid && cur_count == $past(wdata)));

    assert_mask_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && post_valid) |-> !$past(ctrl_masked));

    assert_oneshot_nonincr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(wr_init) && !$past(ctrl_periodic)) |-> cur_count <= $past(cur_count));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(wr_init) && $past(cur_count) != '0 && cur_count != $past(cur_count))
            |-> cur_count == $past(cur_count) - 1'b1);
endmodule

bind cdt_timer cdt_timer_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdata         (wdata),
    .wr_init       (wr_init),
    .cur_count     (cur_count),
    .post_valid    (post_valid),
    .ctrl_masked   (ctrl_w.masked),
    .ctrl_periodic (ctrl_w.periodic)
);

// File: tb/cdt_timer_tb.sv
`timescale 1ns/1ps
module cdt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wdata = '0;
    logic        wr_init = 1'b0, wr_div = 1'b0, wr_ctrl = 1'b0;
    logic [31:0] cur_count;
    logic        post_valid;
    logic [7:0]  post_vector;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    cdt_timer u_dut (.clk(clk), .rst_n(rst_n), .wdata(wdata), .wr_init(wr_init),
        .wr_div(wr_div), .wr_ctrl(wr_ctrl), .cur_count(cur_count),
        .post_valid(post_valid), .post_vector(post_vector));

    // {div code, control word, initial count, cycles}
    localparam logic [83:0] VECS [7] = '{
        {4'h0, 32'h0002_0030, 32'd3, 16'd40},
        {4'hB, 32'h0000_0041, 32'd5, 16'd20},
        {4'h3, 32'h0002_0052, 32'd2, 16'd60},
        {4'h8, 32'h0000_0063, 32'd1, 16'd140},
        {4'h1, 32'h0003_0074, 32'd4, 16'd50},
        {4'hF, 32'h0002_0085, 32'd0, 16'd10},
        {4'h4, 32'h0002_0096, 32'd1, 16'd12}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        wdata = d;
        wr_init = (sel == 0); wr_div = (sel == 1); wr_ctrl = (sel == 2);
        @(negedge clk);
        wr_init = 1'b0; wr_div = 1'b0; wr_ctrl = 1'b0;
    endtask

    function automatic int shift_of(input logic [3:0] code);
        logic [3:0] k;
        int v;
        k = code & 4'hB;
        v = int'(k[1:0]) + (k[3] ? 4 : 0);
        return (v + 1) % 8;
    endfunction

    // expected state n edges after the initial-count write edge
    task automatic model(input int s, input logic [31:0] ctrl, input longint init,
                         input longint n, output longint ec, output bit ep);
        longint ticks, per;
        bit periodic, masked;
        ticks = n >> s;
        per = init + 1;
        periodic = ctrl[17];
        masked = ctrl[16];
        if (init == 0) ec = 0;
        else if (periodic) ec = init - (ticks % per);
        else ec = (ticks >= init) ? 0 : init - ticks;
        ep = (init != 0) && !masked && ((n % (longint'(1) << s)) == 0) && ticks > 0
             && (ticks % per) == 0 && (periodic || ticks == per);
    endtask

    task automatic run(input logic [3:0] code, input logic [31:0] ctrl,
                       input logic [31:0] init, input int ncyc,
                       input string ctag, input string ptag);
        longint ec;
        bit ep;
        int s;
        s = shift_of(code);
        wr(1, {28'd0, code});
        wr(2, ctrl);
        wr(0, init);
        for (int n = 1; n <= ncyc; n++) begin
            @(negedge clk);
            model(s, ctrl, longint'(init), longint'(n), ec, ep);
            check(ctag, cur_count, ec[31:0]);
            check(ptag, {31'd0, post_valid}, {31'd0, ep});
            if (ep) check({ptag, " vector"}, {24'd0, post_vector}, {24'd0, ctrl[7:0]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset count", cur_count, 32'd0);
        check("R1 reset post", {31'd0, post_valid}, 32'd0);
        // default control is masked one-shot, default divide gives shift 1
        wr(0, 32'd2);
        for (int n = 1; n <= 12; n++) begin
            longint ec;
            bit ep;
            @(negedge clk);
            model(1, 32'h0001_0000, 2, longint'(n), ec, ep);
            check("R1 default divide/mask count", cur_count, ec[31:0]);
            check("R1 default mask post", {31'd0, post_valid}, 32'd0);
        end

        for (int i = 0; i < 7; i++) begin
            logic [83:0] v;
            string ct, pt;
            v = VECS[i];
            if (v[47:16] == 32'd0) begin ct = "R8 idle count"; pt = "R8 idle post"; end
            else if (v[65]) begin ct = "R4 R2 R3 periodic count"; pt = v[64] ? "R7 masked post" : "R6 post"; end
            else begin ct = "R5 R2 R3 oneshot count"; pt = "R5 R6 oneshot post"; end
            run(v[83:80], v[79:48], v[47:16], int'(v[15:0]), ct, pt);
        end

        // R9: initial-count write on an expiry edge
        wr(1, 32'hB);
        wr(2, 32'h0002_0011);
        wr(0, 32'd1);
        @(negedge clk);
        check("R9 pre count", cur_count, 32'd0);
        wdata = 32'd5; wr_init = 1'b1;
        @(negedge clk);
        wr_init = 1'b0;
        check("R9 write wins post", {31'd0, post_valid}, 32'd0);
        check("R9 write wins count", cur_count, 32'd5);
        @(negedge clk);
        check("R9 after count", cur_count, 32'd4);

        // R10: control write on an expiry edge
        wr(2, 32'h0002_0021);
        wr(0, 32'd1);
        @(negedge clk);
        wdata = 32'h0002_0042; wr_ctrl = 1'b1;
        @(negedge clk);
        wr_ctrl = 1'b0;
        check("R10 old ctrl post", {31'd0, post_valid}, 32'd1);
        check("R10 old vector", {24'd0, post_vector}, 32'h21);
        @(negedge clk);
        check("R10 gap", {31'd0, post_valid}, 32'd0);
        @(negedge clk);
        check("R10 new ctrl post", {31'd0, post_valid}, 32'd1);
        check("R10 new vector", {24'd0, post_vector}, 32'h42);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule